// File: doc/BRIEF.md
# Banked short-vector register index sequencer

This block turns one short-vector floating-point operation into a stream of per-element register numbers. A start pulse supplies the destination, first-source and second-source register numbers, along with a precision select, an element count and a stride. The sequencer then issues one index triple per enabled cycle. Each triple carries a valid flag and a last flag, and a flag for store-only elements.

The destination's bank sets the operation's class. A destination in a scalar bank gives a single element. A destination in a vector bank gives a vector operation. In that case the second source either stays fixed, when it lies in a scalar bank, or steps along with the destination. Every index moves by its step inside its own bank and wraps there. For a two-operand operation whose source is fixed, the result is computed once and then written to each further destination. Those later elements are marked as stores of that same result.

Top module: `svec_idx_seq`

## Requirements
- R1: With dp_i=0, a destination whose bits [4:3] are zero is scalar: kind_o reads 0 and exactly one element is issued with last_o set, whatever len_i holds.
- R2: With dp_i=1, a destination whose bits [3:2] are zero (registers 0-3 and 16-19) is scalar: kind_o reads 0 and one element is issued with last_o set.
- R3: Advancing an index adds the step only to its low 3 bits (single) or low 2 bits (double), modulo the bank size, and leaves the upper bits unchanged.
- R4: The first element carries the start register numbers. After each element, the destination and first source both advance by stride+1 in single precision or by (stride>>1)+1 in double precision.
- R5: A vector-bank destination with a scalar-bank second source gives kind_o=1, and rm_o keeps its start value on every element.
- R6: When destination and second source are both in vector banks, kind_o=2 and rm_o advances by the destination step on each element.
- R7: len_i holds the element count minus one. A vector operation issues len_i+1 elements, and last_o is set only on the final one.
- R8: With two_op_i=1 and kind 1, the first element has store_o=0. Every later element has store_o=1, its rd_o advanced by one step, and rn_o and rm_o held at their first-element values.
- R9: A start pulse is accepted only when busy_o is low. busy_o rises on the following cycle and falls in the same cycle as the element flagged last. A start pulse while busy_o is high changes nothing.
- R10: All outputs are registered. An element is issued only in a cycle that follows a clock edge with busy_o and en_i both high. While en_i is low, vld_o is low and the indices hold.
- R11: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sequence when idle |
| dp_i | input | 1 | 1 selects double precision, 0 single |
| two_op_i | input | 1 | Operation has only one source |
| len_i | input | 3 | Element count minus one |
| stride_i | input | 2 | Programmed stride |
| rd_i | input | 5 | Start destination register |
| rn_i | input | 5 | Start first-source register |
| rm_i | input | 5 | Start second-source register |
| en_i | input | 1 | Allows one element per cycle |
| busy_o | output | 1 | Sequence in progress |
| vld_o | output | 1 | Element valid this cycle |
| last_o | output | 1 | Final element of the sequence |
| store_o | output | 1 | Element writes the already computed result |
| kind_o | output | 2 | 0 scalar, 1 mixed, 2 vector |
| rd_o | output | 5 | Destination index |
| rn_o | output | 5 | First-source index |
| rm_o | output | 5 | Second-source index |

## Verification
On every cycle, the assertions check the following. A scalar operation is a single element. The destination's bank bits never change inside a sequence. A fixed second source stays fixed. Store-only elements appear only with mixed operations. No element appears while idle or stalled. busy_o falls only together with a last element. The values themselves need the bench's scenarios: the exact wrapped index at each element, the step size for each precision and stride, the element count, and the fact that a start pulse during a busy sequence leaves the running stream unchanged.

// File: rtl/svec_seq_pkg.sv
package svec_seq_pkg;
  typedef enum logic [1:0] {
    KIND_SCALAR = 2'd0,
    KIND_MIXED  = 2'd1,
    KIND_VECTOR = 2'd2
  } vkind_e;
endpackage

// File: rtl/svec_classify.sv
module svec_classify
  import svec_seq_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int LEN_W    = 3,
  parameter int STRIDE_W = 2,
  parameter int SP_LOW_W = 3,
  parameter int DP_LOW_W = 2,
  parameter int SEL_W    = 2,
  parameter int STEP_W   = STRIDE_W + 1
) (
  input  logic                dp_i,
  input  logic                two_op_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [REG_W-1:0]    rd_i,
  input  logic [REG_W-1:0]    rm_i,
  output vkind_e              kind_o,
  output logic [STEP_W-1:0]   step_d_o,
  output logic [STEP_W-1:0]   step_m_o,
  output logic [LEN_W-1:0]    last_idx_o,
  output logic                fanout_o
);
  logic                rd_scal, rm_scal;
  logic [STRIDE_W-1:0] stride_eff;
  logic [STEP_W-1:0]   step;

  always_comb begin
    rd_scal    = dp_i ? (rd_i[DP_LOW_W +: SEL_W] == '0) : (rd_i[SP_LOW_W +: SEL_W] == '0);
    rm_scal    = dp_i ? (rm_i[DP_LOW_W +: SEL_W] == '0) : (rm_i[SP_LOW_W +: SEL_W] == '0);
    stride_eff = dp_i ? (stride_i >> 1) : stride_i;
    step       = STEP_W'(stride_eff) + STEP_W'(1);
    kind_o     = KIND_SCALAR;
    step_d_o   = '0;
    step_m_o   = '0;
    last_idx_o = '0;
    fanout_o   = 1'b0;
    if (!rd_scal) begin
      step_d_o   = step;
      last_idx_o = len_i;
      if (rm_scal) begin
        kind_o   = KIND_MIXED;
        fanout_o = two_op_i;
      end else begin
        kind_o   = KIND_VECTOR;
        step_m_o = step;
      end
    end
  end
endmodule

// File: rtl/svec_bank_adv.sv
module svec_bank_adv #(
  parameter int REG_W    = 5,
  parameter int SP_LOW_W = 3,
  parameter int DP_LOW_W = 2,
  parameter int STEP_W   = 3
) (
  input  logic [REG_W-1:0]  idx_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              dp_i,
  output logic [REG_W-1:0]  nxt_o
);
  logic [REG_W-1:0] sum;

  always_comb begin
    sum = idx_i + REG_W'(step_i);
    if (dp_i) nxt_o = {idx_i[REG_W-1:DP_LOW_W], sum[DP_LOW_W-1:0]};
    else      nxt_o = {idx_i[REG_W-1:SP_LOW_W], sum[SP_LOW_W-1:0]};
  end
endmodule

// File: rtl/svec_idx_seq.sv
module svec_idx_seq
  import svec_seq_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int LEN_W    = 3,
  parameter int STRIDE_W = 2,
  parameter int SP_LOW_W = 3,
  parameter int DP_LOW_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                dp_i,
  input  logic                two_op_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [REG_W-1:0]    rd_i,
  input  logic [REG_W-1:0]    rn_i,
  input  logic [REG_W-1:0]    rm_i,
  input  logic                en_i,
  output logic                busy_o,
  output logic                vld_o,
  output logic                last_o,
  output logic                store_o,
  output logic [1:0]          kind_o,
  output logic [REG_W-1:0]    rd_o,
  output logic [REG_W-1:0]    rn_o,
  output logic [REG_W-1:0]    rm_o
);
  localparam int STEP_W = STRIDE_W + 1;
  localparam int SEL_W  = 2;
  localparam int N_IDX  = 3;  // 0 dest, 1 first source, 2 second source

  vkind_e              cls_kind, kind_q;
  logic [STEP_W-1:0]   cls_step_d, cls_step_m, step_d_q, step_m_q;
  logic [LEN_W-1:0]    cls_last, rem_q;
  logic                cls_fanout, fanout_q, dp_q, first_q, busy_q;
  logic                vld_q, last_q, store_q;
  logic [REG_W-1:0]    cur_q [N_IDX];
  logic [REG_W-1:0]    nxt   [N_IDX];
  logic [REG_W-1:0]    out_q [N_IDX];
  logic [REG_W-1:0]    start_idx [N_IDX];

  assign start_idx[0] = rd_i;
  assign start_idx[1] = rn_i;
  assign start_idx[2] = rm_i;

  svec_classify #(
    .REG_W(REG_W), .LEN_W(LEN_W), .STRIDE_W(STRIDE_W),
    .SP_LOW_W(SP_LOW_W), .DP_LOW_W(DP_LOW_W), .SEL_W(SEL_W), .STEP_W(STEP_W)
  ) u_cls (
    .dp_i(dp_i), .two_op_i(two_op_i), .len_i(len_i), .stride_i(stride_i),
    .rd_i(rd_i), .rm_i(rm_i), .kind_o(cls_kind), .step_d_o(cls_step_d),
    .step_m_o(cls_step_m), .last_idx_o(cls_last), .fanout_o(cls_fanout)
  );

  for (genvar g = 0; g < N_IDX; g++) begin : g_adv
    if (g == N_IDX - 1) begin : g_src2
      svec_bank_adv #(.REG_W(REG_W), .SP_LOW_W(SP_LOW_W), .DP_LOW_W(DP_LOW_W), .STEP_W(STEP_W))
        u_adv (.idx_i(cur_q[g]), .step_i(step_m_q), .dp_i(dp_q), .nxt_o(nxt[g]));
    end else begin : g_dn
      svec_bank_adv #(.REG_W(REG_W), .SP_LOW_W(SP_LOW_W), .DP_LOW_W(DP_LOW_W), .STEP_W(STEP_W))
        u_adv (.idx_i(cur_q[g]), .step_i(step_d_q), .dp_i(dp_q), .nxt_o(nxt[g]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      first_q  <= 1'b0;
      dp_q     <= 1'b0;
      fanout_q <= 1'b0;
      kind_q   <= KIND_SCALAR;
      step_d_q <= '0;
      step_m_q <= '0;
      rem_q    <= '0;
      vld_q    <= 1'b0;
      last_q   <= 1'b0;
      store_q  <= 1'b0;
      for (int i = 0; i < N_IDX; i++) begin
        cur_q[i] <= '0;
        out_q[i] <= '0;
      end
    end else begin
      vld_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q   <= 1'b1;
        first_q  <= 1'b1;
        dp_q     <= dp_i;
        fanout_q <= cls_fanout;
        kind_q   <= cls_kind;
        step_d_q <= cls_step_d;
        step_m_q <= cls_step_m;
        rem_q    <= cls_last;
        for (int i = 0; i < N_IDX; i++) cur_q[i] <= start_idx[i];
      end else if (busy_q && en_i) begin
        vld_q   <= 1'b1;
        last_q  <= (rem_q == '0);
        store_q <= fanout_q && !first_q;
        first_q <= 1'b0;
        for (int i = 0; i < N_IDX; i++) out_q[i] <= cur_q[i];
        cur_q[0] <= nxt[0];
        // one-to-many: only the destination keeps moving
        if (!fanout_q) cur_q[1] <= nxt[1];
        cur_q[2] <= nxt[2];
        rem_q    <= rem_q - 1'b1;
        if (rem_q == '0) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign vld_o   = vld_q;
  assign last_o  = last_q;
  assign store_o = store_q;
  assign kind_o  = kind_q;
  assign rd_o    = out_q[0];
  assign rn_o    = out_q[1];
  assign rm_o    = out_q[2];

  AST_SCALAR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && kind_o == KIND_SCALAR) |-> last_o); // R1
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !last_o) |=> $stable(rd_o[REG_W-1:SP_LOW_W])); // R3
  AST_FIXED_SRC2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !last_o && kind_o == KIND_MIXED) |=> $stable(rm_o)); // R5
  AST_STORE_MIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && store_o) |-> (kind_o == KIND_MIXED)); // R8
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (vld_o && last_o)); // R9
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> $stable(kind_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !vld_o); // R10
  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !en_i) |=> (!vld_o && $stable(rd_o))); // R10
endmodule

// File: tb/svec_idx_seq_test.sv
`timescale 1ns/1ps
module svec_idx_seq_test;
  typedef struct packed {
    logic       dp;
    logic       two;
    logic [2:0] len;
    logic [1:0] stride;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 3'd5, 2'd0, 5'd5,  5'd1,  5'd2 },  // R1 sp scalar
    '{1'b0, 1'b0, 3'd3, 2'd0, 5'd9,  5'd17, 5'd25},  // R6 R7 sp vector
    '{1'b0, 1'b0, 3'd4, 2'd1, 5'd14, 5'd22, 5'd30},  // R3 R4 sp wrap
    '{1'b0, 1'b0, 3'd2, 2'd2, 5'd8,  5'd16, 5'd3 },  // R5 sp mixed
    '{1'b1, 1'b0, 3'd3, 2'd0, 5'd17, 5'd4,  5'd8 },  // R2 dp scalar
    '{1'b1, 1'b0, 3'd3, 2'd3, 5'd6,  5'd10, 5'd13},  // R3 R4 dp wrap
    '{1'b0, 1'b1, 3'd3, 2'd0, 5'd24, 5'd0,  5'd2 },  // R8 sp one-to-many
    '{1'b1, 1'b1, 3'd2, 2'd2, 5'd20, 5'd7,  5'd16},  // R8 dp one-to-many
    '{1'b0, 1'b1, 3'd1, 2'd0, 5'd8,  5'd0,  5'd16},  // R6 two-op vector
    '{1'b1, 1'b0, 3'd4, 2'd1, 5'd7,  5'd27, 5'd4 }   // R4 dp stride 1
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, dp_i = 1'b0, two_op_i = 1'b0, en_i = 1'b1;
  logic [2:0] len_i = '0;
  logic [1:0] stride_i = '0;
  logic [4:0] rd_i = '0, rn_i = '0, rm_i = '0;
  logic busy_o, vld_o, last_o, store_o;
  logic [1:0] kind_o;
  logic [4:0] rd_o, rn_o, rm_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  svec_idx_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .dp_i(dp_i), .two_op_i(two_op_i),
    .len_i(len_i), .stride_i(stride_i), .rd_i(rd_i), .rn_i(rn_i), .rm_i(rm_i), .en_i(en_i),
    .busy_o(busy_o), .vld_o(vld_o), .last_o(last_o), .store_o(store_o), .kind_o(kind_o),
    .rd_o(rd_o), .rn_o(rn_o), .rm_o(rm_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  function automatic logic is_scal(input logic [4:0] r, input logic dp);
    return dp ? (r[3:2] == 2'b00) : (r[4:3] == 2'b00);
  endfunction

  function automatic logic [4:0] mv(input logic [4:0] r, input int k, input logic dp);
    logic [4:0] v;
    v = r;
    if (dp) v[1:0] = 2'(int'(r[1:0]) + k);
    else    v[2:0] = 3'(int'(r[2:0]) + k);
    return v;
  endfunction

  task automatic load(input vec_t v);
    dp_i = v.dp; two_op_i = v.two; len_i = v.len; stride_i = v.stride;
    rd_i = v.rd; rn_i = v.rn; rm_i = v.rm;
  endtask

  task automatic run_vec(input vec_t v);
    int kind, nel, st;
    logic fan;
    @(negedge clk);
    load(v);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    eq("R9 busy after start", int'(busy_o), 1);
    st   = v.dp ? (int'(v.stride) >> 1) + 1 : int'(v.stride) + 1;
    kind = is_scal(v.rd, v.dp) ? 0 : (is_scal(v.rm, v.dp) ? 1 : 2);
    nel  = (kind == 0) ? 1 : int'(v.len) + 1;
    fan  = v.two && kind == 1;
    for (int e = 0; e < nel; e++) begin
      @(negedge clk);
      eq("R10 vld", int'(vld_o), 1);
      eq("R1 R2 R5 R6 kind", int'(kind_o), kind);
      eq("R3 R4 rd", int'(rd_o), int'(mv(v.rd, e * st, v.dp)));
      eq("R4 R8 rn", int'(rn_o), fan ? int'(v.rn) : int'(mv(v.rn, e * st, v.dp)));
      eq("R5 R6 rm", int'(rm_o), (kind == 2) ? int'(mv(v.rm, e * st, v.dp)) : int'(v.rm));
      eq("R7 last", int'(last_o), (e == nel - 1) ? 1 : 0);
      eq("R8 store", int'(store_o), (fan && e > 0) ? 1 : 0);
    end
    eq("R9 busy falls with last", int'(busy_o), 0);
    @(negedge clk);
    eq("R10 vld after end", int'(vld_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t s;
    // R11 reset state
    repeat (2) @(negedge clk);
    eq("R11 reset outputs", int'({busy_o, vld_o, last_o, store_o, kind_o, rd_o, rn_o, rm_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    eq("R10 idle vld", int'(vld_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10 stall: en_i low holds the sequence
    s = '{1'b0, 1'b0, 3'd3, 2'd0, 5'd9, 5'd17, 5'd25};
    en_i = 1'b0;
    load(s);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      eq("R10 stalled vld", int'(vld_o), 0);
      eq("R10 stalled busy", int'(busy_o), 1);
    end
    en_i = 1'b1;
    @(negedge clk);
    eq("R10 resume rd", int'(rd_o), 9);
    en_i = 1'b0;
    @(negedge clk);
    eq("R10 stall vld", int'(vld_o), 0);
    eq("R10 stall rd held", int'(rd_o), 9);
    en_i = 1'b1;
    @(negedge clk);
    eq("R10 after stall rd", int'(rd_o), 10);
    @(negedge clk);
    eq("R10 rd", int'(rd_o), 11);
    @(negedge clk);
    eq("R10 final rd", int'(rd_o), 12);
    eq("R7 final last", int'(last_o), 1);

    // R9 start while busy is ignored
    s = '{1'b0, 1'b0, 3'd2, 2'd0, 5'd8, 5'd16, 5'd16};
    @(negedge clk);
    load(s);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    eq("R9 first rd", int'(rd_o), 8);
    load('{1'b0, 1'b0, 3'd0, 2'd3, 5'd24, 5'd2, 5'd3});
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    eq("R9 rd unchanged by start", int'(rd_o), 9);
    eq("R9 kind unchanged", int'(kind_o), 2);
    @(negedge clk);
    eq("R9 last rd", int'(rd_o), 10);
    eq("R9 last flag", int'(last_o), 1);
    eq("R9 busy low", int'(busy_o), 0);
    repeat (2) begin
      @(negedge clk);
      eq("R9 no new sequence", int'(vld_o | busy_o), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule